// File: doc/BRIEF.md
# Byte-Addressed Register File Behind an I2C Target

This block puts a 64-byte register space on a two-wire serial bus as a target device. The lowest eight locations are set aside for timekeeping and control values kept by a neighbouring block. The remaining locations serve as general-purpose storage. Inside the block all 64 bytes are plain storage. An internal pointer selects the byte to access. A write transfer loads the pointer from its first data byte. Each later byte is stored at the pointer, which then steps forward. A read transfer sends bytes from the pointer onward until the controller declines a byte.

SCL and SDA are sampled by the system clock through a synchronizer. START and STOP are detected from the synchronized levels. The block drives SDA only through an open-drain enable: when that enable is high, the line is pulled low. A power-fail input aborts any transfer and clears the pointer. It also keeps the target deaf to the bus for as long as it is high, plus a recovery window of `REC_CYCLES` system clocks after it drops.

Top module: `regfile_i2c_target`

## Requirements
- R1: A START (SDA falling while SCL is high) begins address matching, and a STOP (SDA rising while SCL is high) returns the target to idle. The target only begins to pull SDA low while SCL is low.
- R2: The first byte after START holds the 7-bit device address 0x68 in bits 7..1 and the direction in bit 0 (0 = write, 1 = read), so 0xD0 and 0xD1 are the two valid bytes. The target acknowledges a matching byte by pulling SDA low during the ninth clock.
- R3: An address byte that does not match is not acknowledged. Every byte after it is also ignored and not acknowledged until the next START.
- R4: In a write transfer, the byte after the address loads the pointer from its low 6 bits; bits 7..6 are ignored. Each later byte is stored at the pointer, and the pointer then increments. The target acknowledges the word-address byte and every data byte.
- R5: In a read transfer, the byte at the pointer is sent MSB first. The pointer increments only when the controller acknowledges the byte (SDA low on the ninth clock).
- R6: A read transfer that has no pointer write before it starts at the pointer value left by the previous access.
- R7: After the controller declines a byte (SDA high on the ninth clock), the target releases SDA and drives nothing until the next START.
- R8: The pointer wraps from 63 to 0, on writes and on acknowledged reads alike.
- R9: While the power-fail input is high, SDA is released, the pointer is held at 0, any transfer in progress is dropped without storing a partial byte, and START conditions are ignored.
- R10: For `REC_CYCLES` system clocks after the power-fail input falls, START conditions are still ignored and no byte is acknowledged.
- R11: A repeated START in the middle of a transfer returns the target to address matching, so a pointer write can be followed at once by a read.
- R12: Synchronous reset releases SDA and clears the pointer to 0. It leaves the stored bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| pwr_fail | input | 1 | Supply-out-of-tolerance indication, synchronous to clk |
| sda_oe | output | 1 | Registered open-drain enable; 1 pulls SDA low |

## Verification
The bench targets how the pointer behaves at its edges:
- Two reads that the controller declines must return the same byte. A design that stepped on every byte would skip one.
- A burst that starts at location 62 must land its third byte at location 0. A pointer without wrap would write outside the space.
- A power failure in the middle of a byte must leave the next location untouched and must put the pointer at 0. A design that finished the aborted byte would corrupt storage, and one that kept the pointer would read back the wrong location.
- An address sent inside the recovery window, and the bytes after a wrong address, must both go unacknowledged. A design that re-armed early, or that kept listening after a mismatch, would acknowledge them.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_RX_ACK,
    S_TX,
    S_TX_ACK
  } bus_state_t;

  typedef enum logic [1:0] {
    P_DEV,
    P_WORD,
    P_DATA
  } rx_phase_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_s, sda_s, scl_q, sda_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_i;
          sda_sh <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
          sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign sda_s = sda_sh[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_pf_guard.sv
module i2c_pf_guard #(
  parameter int REC_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_fail,
  output logic blocked
);

  localparam int CW = $clog2(REC_CYCLES + 1);

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
    end else if (pwr_fail) begin
      hold_cnt <= CW'(REC_CYCLES);
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end

  assign blocked = pwr_fail | (hold_cnt != '0);

endmodule

// File: rtl/i2c_rf_store.sv
module i2c_rf_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/regfile_i2c_target.sv
module regfile_i2c_target
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h68,
  parameter int         DEPTH      = 64,
  parameter int         SYNC_STAGES = 2,
  parameter int         REC_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic pwr_fail,
  output logic sda_oe
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det, blocked;
  bus_state_t    state;
  rx_phase_t     phase;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [AW-1:0] ptr;
  logic          rw;
  logic          host_ack;
  logic          wr_fire;
  logic [7:0]    rd_data;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_pf_guard #(.REC_CYCLES(REC_CYCLES)) u_guard (
    .clk(clk), .rst(rst), .pwr_fail(pwr_fail), .blocked(blocked)
  );

  assign wr_fire = !blocked && state == S_RX && phase == P_DATA &&
                   scl_fall && bitcnt == 4'd8;

  i2c_rf_store #(.DEPTH(DEPTH), .DW(8)) u_store (
    .clk(clk), .we(wr_fire), .waddr(ptr), .wdata(shreg),
    .raddr(ptr), .rdata(rd_data)
  );

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      phase    <= P_DEV;
      bitcnt   <= '0;
      shreg    <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (blocked) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
      if (pwr_fail) ptr <= '0;
    end else if (start_det) begin
      state  <= S_RX;
      phase  <= P_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            case (phase)
              P_DEV: begin
                if (shreg[7:1] == DEV_ADDR) begin
                  rw     <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= S_RX_ACK;
                end else begin
                  state <= S_IDLE;
                end
              end
              P_WORD: begin
                ptr    <= shreg[AW-1:0];
                sda_oe <= 1'b1;
                state  <= S_RX_ACK;
              end
              default: begin
                ptr    <= step(ptr);
                sda_oe <= 1'b1;
                state  <= S_RX_ACK;
              end
            endcase
          end
        end
        S_RX_ACK: begin
          if (scl_fall) begin
            if (phase == P_DEV && rw) begin
              state  <= S_TX;
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
              bitcnt <= '0;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_RX;
              phase  <= (phase == P_DEV) ? P_WORD : P_DATA;
            end
          end
        end
        S_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= S_TX_ACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end
        end
        S_TX_ACK: begin
          if (scl_rise) begin
            host_ack <= ~sda_s;
            if (!sda_s) ptr <= step(ptr);
          end else if (scl_fall) begin
            if (host_ack) begin
              state  <= S_TX;
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: begin
          sda_oe <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/regfile_i2c_target_chk.sv
module regfile_i2c_target_chk
  import i2c_rf_pkg::*;
#(
  parameter int REC_CYCLES = 64,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          pwr_fail,
  input logic          sda_oe,
  input logic          sda_lvl,
  input logic          scl_rise,
  input bus_state_t    state,
  input logic [AW-1:0] ptr
);

  localparam int W = $clog2(REC_CYCLES + 1);
  logic [W-1:0] since_pf;

  always_ff @(posedge clk) begin
    if (rst) since_pf <= W'(REC_CYCLES);
    else if (pwr_fail) since_pf <= '0;
    else if (since_pf < W'(REC_CYCLES)) since_pf <= since_pf + 1'b1;
  end

  // R1
  a_r1_drive_low_phase: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  // R3
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && $past(state) == S_IDLE) |-> !sda_oe);

  // R5
  a_r5_nack_holds_ptr: assert property (@(posedge clk) disable iff (rst)
    (state == S_TX_ACK && scl_rise && sda_lvl && !pwr_fail) |=> $stable(ptr));

  // R9
  a_r9_pf_release: assert property (@(posedge clk) disable iff (rst)
    pwr_fail |=> !sda_oe);

  // R10
  a_r10_recovery_quiet: assert property (@(posedge clk) disable iff (rst)
    (since_pf < W'(REC_CYCLES)) |-> !sda_oe);

endmodule

bind regfile_i2c_target regfile_i2c_target_chk #(
  .REC_CYCLES(REC_CYCLES), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .pwr_fail(pwr_fail),
  .sda_oe(sda_oe), .sda_lvl(sda_s), .scl_rise(scl_rise),
  .state(state), .ptr(ptr)
);

// File: tb/regfile_i2c_target_test.sv
module regfile_i2c_target_test;

  localparam int Q = 8;
  localparam int NVEC = 6;
  // {word address sent, read-back address, data}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 8'h9C},
    {8'h07, 8'h07, 8'h3F},
    {8'h08, 8'h08, 8'hE1},
    {8'h2A, 8'h2A, 8'h55},
    {8'h3F, 8'h3F, 8'hA7},
    {8'hC5, 8'h05, 8'h0D}
  };

  logic clk = 0, rst = 1, scl = 1, sda_m = 1, pwr_fail = 0;
  logic sda_oe;
  logic line;
  int checks = 0, errors = 0, cyc = 0;

  assign line = sda_m & ~sda_oe;
  always #4 clk = ~clk;

  regfile_i2c_target uut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(line),
    .pwr_fail(pwr_fail), .sda_oe(sda_oe)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bstart();
    sda_m = 1; tick(Q); scl = 1; tick(Q); sda_m = 0; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic bstop();
    sda_m = 0; tick(Q); scl = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1; tick(Q); scl = 1; tick(Q);
    acked = (line == 1'b0);
    tick(Q); scl = 0; tick(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; tick(Q); scl = 1; tick(Q);
      d[i] = line;
      tick(Q); scl = 0;
    end
    tick(Q);
    send_bit(~give_ack);
    sda_m = 1;
  endtask

  task automatic write_one(input logic [7:0] wa, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bstart(); send_byte(8'hD0, a0); send_byte(wa, a1); send_byte(d, a2); bstop();
    ok = a0 & a1 & a2;
  endtask

  task automatic read_at(input logic [7:0] wa, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bstart(); send_byte(8'hD0, a0); send_byte(wa, a1);
    bstart(); send_byte(8'hD1, a2); recv_byte(1'b0, d); bstop();
    ok = a0 & a1 & a2;
  endtask

  task automatic read_cur(output logic [7:0] d);
    logic a0;
    bstart(); send_byte(8'hD1, a0); recv_byte(1'b0, d);
    tick(2);
    chk("R7 sda released after nack", sda_oe, 0);
    bstop();
  endtask

  initial begin
    logic ok, a0, a1, a2;
    logic [7:0] d;
    tick(5);
    chk("R12 sda released in reset", sda_oe, 0);
    rst = 0;
    tick(5);

    // R1 R2: START then matching address is acknowledged
    bstart(); send_byte(8'hD0, a0); bstop();
    chk("R1 R2 address ack", a0, 1);

    // R3: wrong address not acked, following byte ignored
    bstart(); send_byte(8'hA0, a0); send_byte(8'h00, a1); bstop();
    chk("R3 wrong address nack", a0, 0);
    chk("R3 following byte ignored", a1, 0);

    // table of writes with read-back through repeated START (R4, R11)
    for (int i = 0; i < NVEC; i++) begin
      write_one(VEC[i][23:16], VEC[i][7:0], ok);
      chk("R4 write acks", ok, 1);
      read_at(VEC[i][15:8], d, ok);
      chk("R11 repeated start read acks", ok, 1);
      chk("R4 R5 read back", d, VEC[i][7:0]);
    end

    // R12: reset clears pointer, keeps storage
    rst = 1; tick(3); rst = 0; tick(3);
    read_cur(d);
    chk("R12 pointer 0 after reset", d, 8'h9C);

    // R8: burst write wraps 63 -> 0
    bstart(); send_byte(8'hD0, a0); send_byte(8'd62, a0);
    send_byte(8'hA1, a0); send_byte(8'hB2, a1); send_byte(8'hC3, a2); bstop();
    chk("R4 burst data acked", a0 & a1 & a2, 1);
    bstart(); send_byte(8'hD0, a0); send_byte(8'd62, a0);
    bstart(); send_byte(8'hD1, a0);
    recv_byte(1'b1, d); chk("R5 burst byte 62", d, 8'hA1);
    recv_byte(1'b1, d); chk("R5 burst byte 63", d, 8'hB2);
    recv_byte(1'b0, d); chk("R8 wrapped byte 0", d, 8'hC3);
    bstop();
    read_cur(d);
    chk("R6 R5 current read after nack", d, 8'hC3);

    // R5 R6: pointer moves on ack only
    write_one(8'd20, 8'h11, ok);
    write_one(8'd21, 8'h22, ok);
    bstart(); send_byte(8'hD0, a0); send_byte(8'd20, a0); bstop();
    read_cur(d); chk("R6 resume at set pointer", d, 8'h11);
    read_cur(d); chk("R5 nack holds pointer", d, 8'h11);
    bstart(); send_byte(8'hD1, a0);
    recv_byte(1'b1, d); chk("R5 first acked byte", d, 8'h11);
    recv_byte(1'b0, d); chk("R5 advanced after ack", d, 8'h22);
    bstop();
    read_cur(d); chk("R6 resume after mixed read", d, 8'h22);

    // R9 R10: power failure
    write_one(8'd31, 8'h31, ok);
    write_one(8'd40, 8'h10, ok);
    bstart(); send_byte(8'hD0, a0); send_byte(8'd30, a0); send_byte(8'h5A, a0);
    for (int i = 7; i >= 4; i--) send_bit(i[0]);
    pwr_fail = 1; tick(2);
    chk("R9 sda released on power fail", sda_oe, 0);
    for (int i = 3; i >= 0; i--) send_bit(i[0]);
    sda_m = 1; tick(4*Q);
    bstop();
    bstart(); send_byte(8'hD0, a0); send_byte(8'd40, a1); send_byte(8'h77, a2); bstop();
    chk("R9 address ignored in power fail", a0, 0);
    chk("R9 data ignored in power fail", a2, 0);
    pwr_fail = 0;
    bstart(); send_byte(8'hD0, a0); bstop();
    chk("R10 address ignored in recovery", a0, 0);
    tick(100);
    read_cur(d); chk("R9 pointer reset to 0", d, 8'hC3);
    read_at(8'd31, d, ok); chk("R9 aborted byte not stored", d, 8'h31);
    read_at(8'd40, d, ok); chk("R9 blocked write not stored", d, 8'h10);
    read_at(8'd30, d, ok); chk("R10 access restored", d, 8'h5A);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule